// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision timer with a 12-bit down-counter. Software starts it, and later refreshes it, with a keyed write to a control word. A refresh is honoured only in the late part of the count, once the counter has dropped to or below a programmed window threshold. A refresh that arrives too early is treated as a fault, and so is letting the counter run out. Either fault sets a sticky error flag. When the reset enable bit is set, each fault also emits a one-cycle reset request.

The counter runs from a prescaled clock whose divide ratio is a power of two. A protect word can freeze the two configuration words so that stray writes cannot change the timing once the setup is done. Power-state and debug inputs can suspend counting. A suspended counter keeps its value and carries on from it when the suspension ends.

The register port is a plain single-cycle write strobe with a combinational read. It has four word addresses: configuration A at 0, configuration B at 1, control and count at 2, and protect at 3.

Top module: `wdog_window`

## Requirements
- R1: After reset the counter is idle and reads 0 with the running bit 0. Error and reset request are low. Word 0 reads 0x1FFF (reload 0xFFF, reset enable 1, sleep halt 0). Word 1 reads 0x0FFF (delta 0xFFF, prescale 0). Word 3 reads 0, meaning unlocked.
- R2: A write to word 2 with bit 0 set and bits [31:16] equal to 0x5FA0 is a kick. On an idle timer a kick loads the reload value (word 0 bits [11:0]) and sets the running bit, which is bit 12 of the word 2 read. A write to word 2 with any other key has no effect.
- R3: While running and not halted, the counter decrements once every 2^N clock cycles, where N is word 1 bits [14:12]. The first decrement comes 2^N cycles after a kick. Word 2 bits [11:0] read the count.
- R4: A kick on a running timer whose count is less than or equal to the delta (word 1 bits [11:0]) reloads the counter with the reload value.
- R5: A kick on a running timer whose count is above the delta sets the error flag and leaves the count unchanged.
- R6: A decrement that is due while the count is 0 sets the error flag and stops the timer. The running bit clears and the count stays at 0.
- R7: Each error event (R5 or R6) drives the reset request high for exactly one cycle when word 0 bit 12 is 1. When that bit is 0, the reset request stays low.
- R8: Once set, the error flag stays high until system reset, even after later accepted reloads.
- R9: Writing 0x35CA to word 3 unlocks the configuration, and writing any other value locks it. Word 3 bit 0 reads the lock state. While locked, writes to words 0 and 1 are ignored. Words 2 and 3 remain writable whether locked or not.
- R10: Counting is suspended with the count held in three cases: while the deep-sleep-2 input is high; while the sleep or deep-sleep-1 input is high and word 0 bit 13 is 1; and while the debug input and the debug freeze input are both high. Counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pm_sleep | input | 1 | Sleep state active |
| pm_deep1 | input | 1 | First deep-sleep level active |
| pm_deep2 | input | 1 | Second deep-sleep level active |
| dbg_active | input | 1 | Debug state active |
| dbg_freeze | input | 1 | Freeze counting while in debug |
| wdt_err | output | 1 | Sticky error flag |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions check on every cycle the properties that need no history beyond one cycle:
- the reset request lasts one cycle and never appears without the error flag;
- the error flag never falls;
- the count moves by at most one step unless a control write occurs;
- a halt holds the count;
- a locked configuration does not change.

Only the bench scenarios can show the behaviours that depend on values built up over many cycles:
- the window decision against the delta at its exact boundary;
- the prescaled decrement rate for several divide ratios;
- the exact cycle of underflow;
- the key values that are rejected.

// File: rtl/wdog_pkg.sv
// Package: shared constants and the configuration record of the windowed watchdog.
// Assumes a 32-bit register bus with four word addresses.
package wdog_pkg;

    localparam int CNT_W  = 12;
    localparam int PSC_W  = 3;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;

    localparam logic [KEY_W-1:0] KEY_KICK   = 16'h5FA0;
    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h35CA;

    typedef enum logic [1:0] {
        ADDR_CFG_A = 2'd0,
        ADDR_CFG_B = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_PROT  = 2'd3
    } waddr_e;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] delta;
        logic [PSC_W-1:0] psc;
        logic             rst_en;
        logic             sleep_halt;
    } cfg_t;

endpackage

// File: rtl/wdog_regs.sv
// Register file: holds the configuration, the lock state and decodes keyed kicks.
// Assumes writes are single-cycle strobes; a kick is a one-cycle pulse.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PSC_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic          locked,
    output logic          kick
);

    localparam int KEY_LSB = DW - KEY_W;

    cfg_t cfg_q;
    logic locked_q;
    logic wr_a, wr_b, wr_prot;

    // Decode the write strobes for each word.
    always_comb begin
        wr_a    = we && (addr == ADDR_CFG_A) && !locked_q;
        wr_b    = we && (addr == ADDR_CFG_B) && !locked_q;
        wr_prot = we && (addr == ADDR_PROT);
        kick    = we && (addr == ADDR_CTRL) && wdata[0]
                  && (wdata[DW-1:KEY_LSB] == KEY_KICK);
    end

    // Configuration storage, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.reload     <= '1;
            cfg_q.delta      <= '1;
            cfg_q.psc        <= '0;
            cfg_q.rst_en     <= 1'b1;
            cfg_q.sleep_halt <= 1'b0;
        end else begin
            if (wr_a) begin
                cfg_q.reload     <= wdata[CW-1:0];
                cfg_q.rst_en     <= wdata[CW];
                cfg_q.sleep_halt <= wdata[CW+1];
            end
            if (wr_b) begin
                cfg_q.delta <= wdata[CW-1:0];
                cfg_q.psc   <= wdata[CW +: PW];
            end
        end
    end

    // Lock state: the unlock key opens, any other value closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (wr_prot)
            locked_q <= (wdata[KEY_W-1:0] != KEY_UNLOCK);
    end

    assign cfg    = cfg_q;
    assign locked = locked_q;

endmodule

// File: rtl/wdog_prescale.sv
// Prescaler: emits a tick every 2^sel enabled cycles.
// Assumes clr restarts the phase so the first tick comes 2^sel cycles after it.
module wdog_prescale #(
    parameter int PW = wdog_pkg::PSC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          clr,
    input  logic [PW-1:0] sel,
    output logic          tick
);

    localparam int PCW = (1 << PW) - 1;

    logic [PCW-1:0] pcnt_q;
    logic [PCW-1:0] mask;

    // Low sel bits of the phase counter must all be one for a tick.
    always_comb begin
        mask = ~({PCW{1'b1}} << sel);
        tick = run_en && ((pcnt_q & mask) == mask);
    end

    // Phase counter advances only while counting is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (clr)
            pcnt_q <= '0;
        else if (run_en)
            pcnt_q <= pcnt_q + 1'b1;
    end

endmodule

// File: rtl/wdog_core.sv
// Counter core: down-counter, window check, sticky error and reset pulse.
// Assumes kick has priority over a tick in the same cycle.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] delta,
    input  logic          rst_en,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          err,
    output logic          rst_req
);

    logic [CW-1:0] cnt_q;
    logic          run_q, err_q, req_q;
    logic          in_window, early, underflow;

    // Classify the current event.
    always_comb begin
        in_window = (cnt_q <= delta);
        early     = kick && run_q && !in_window;
        underflow = !kick && tick && (cnt_q == '0);
    end

    // Count, reload and stop on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (kick) begin
            if (!run_q || in_window) begin
                cnt_q <= reload;
                run_q <= 1'b1;
            end
        end else if (tick) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky error flag and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            req_q <= (early || underflow) && rst_en;
            if (early || underflow)
                err_q <= 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign running = run_q;
    assign err     = err_q;
    assign rst_req = req_q;

endmodule

// File: rtl/wdog_window.sv
// Top: windowed watchdog with keyed kick, lockable setup and mode-dependent halt.
// Assumes all inputs are synchronous to clk.
module wdog_window
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PSC_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          pm_sleep,
    input  logic          pm_deep1,
    input  logic          pm_deep2,
    input  logic          dbg_active,
    input  logic          dbg_freeze,
    output logic          wdt_err,
    output logic          wdt_rst_req
);

    cfg_t          cfg;
    logic          locked, kick, tick, halt, running;
    logic [CW-1:0] cnt_now;

    wdog_regs #(.CW(CW), .PW(PW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cfg    (cfg),
        .locked (locked),
        .kick   (kick)
    );

    // Suspend counting according to power and debug state.
    always_comb begin
        halt = pm_deep2
             || ((pm_sleep || pm_deep1) && cfg.sleep_halt)
             || (dbg_active && dbg_freeze);
    end

    wdog_prescale #(.PW(PW)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (running && !halt),
        .clr    (kick),
        .sel    (cfg.psc),
        .tick   (tick)
    );

    wdog_core #(.CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick),
        .tick    (tick),
        .reload  (cfg.reload),
        .delta   (cfg.delta),
        .rst_en  (cfg.rst_en),
        .cnt     (cnt_now),
        .running (running),
        .err     (wdt_err),
        .rst_req (wdt_rst_req)
    );

    // Read multiplexer over the four words.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CFG_A: begin
                bus_rdata[CW-1:0] = cfg.reload;
                bus_rdata[CW]     = cfg.rst_en;
                bus_rdata[CW+1]   = cfg.sleep_halt;
            end
            ADDR_CFG_B: begin
                bus_rdata[CW-1:0]  = cfg.delta;
                bus_rdata[CW +: PW] = cfg.psc;
            end
            ADDR_CTRL: begin
                bus_rdata[CW-1:0] = cnt_now;
                bus_rdata[CW]     = running;
            end
            default: bus_rdata[0] = locked;
        endcase
    end

endmodule

// File: rtl/wdog_window_chk.sv
// Checker: cycle properties of the windowed watchdog, bound to the top module.
// Assumes the top-level internal names cfg, cnt_now, running and locked.
module wdog_window_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic             pm_sleep,
    input logic             pm_deep1,
    input logic             pm_deep2,
    input logic             dbg_active,
    input logic             dbg_freeze,
    input logic             wdt_err,
    input logic             wdt_rst_req,
    input cfg_t             cfg,
    input logic [CNT_W-1:0] cnt_now,
    input logic             locked
);

    logic ctrl_wr, cfg_wr, halted;
    assign ctrl_wr = bus_we && (bus_addr == 2'd2);
    assign cfg_wr  = bus_we && (bus_addr[1] == 1'b0);
    assign halted  = pm_deep2 || (dbg_active && dbg_freeze)
                   || ((pm_sleep || pm_deep1) && cfg.sleep_halt);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    p_req_with_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> wdt_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_err |=> wdt_err);

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> (cnt_now == $past(cnt_now)) || (cnt_now + 1'b1 == $past(cnt_now)));

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !ctrl_wr) |=> $stable(cnt_now));

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cfg_wr) |=> $stable(cfg));

    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_err && !ctrl_wr && cnt_now != '0) |=> !wdt_err);

endmodule

bind wdog_window wdog_window_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .pm_sleep    (pm_sleep),
    .pm_deep1    (pm_deep1),
    .pm_deep2    (pm_deep2),
    .dbg_active  (dbg_active),
    .dbg_freeze  (dbg_freeze),
    .wdt_err     (wdt_err),
    .wdt_rst_req (wdt_rst_req),
    .cfg         (cfg),
    .cnt_now     (cnt_now),
    .locked      (locked)
);

// File: tb/wdog_window_tb.sv
`timescale 1ns/1ps
// Bench: vector table of window decisions, then directed corner-case tests.
module wdog_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pm_sleep = 1'b0, pm_deep1 = 1'b0, pm_deep2 = 1'b0;
    logic        dbg_active = 1'b0, dbg_freeze = 1'b0;
    logic        wdt_err, wdt_rst_req;

    int n_total = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    wdog_window u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pm_sleep(pm_sleep), .pm_deep1(pm_deep1), .pm_deep2(pm_deep2),
        .dbg_active(dbg_active), .dbg_freeze(dbg_freeze),
        .wdt_err(wdt_err), .wdt_rst_req(wdt_rst_req)
    );

    localparam logic [31:0] KICK = 32'h5FA0_0001;

    // Fields: reload, delta, prescale N, idle cycles before reload, reset enable.
    localparam int NV = 9;
    localparam logic [40:0] VEC [0:NV-1] = '{
        {12'd100,  12'd50,   4'd0, 12'd60,  1'b1},
        {12'd100,  12'd50,   4'd0, 12'd20,  1'b1},
        {12'd100,  12'd50,   4'd0, 12'd50,  1'b1},
        {12'd100,  12'd50,   4'd0, 12'd49,  1'b0},
        {12'd40,   12'd10,   4'd2, 12'd128, 1'b1},
        {12'd40,   12'd10,   4'd2, 12'd119, 1'b1},
        {12'hFFF,  12'hFFF,  4'd0, 12'd0,   1'b1},
        {12'd20,   12'd5,    4'd3, 12'd100, 1'b0},
        {12'd20,   12'd5,    4'd3, 12'd120, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; returns at the next negedge with the reset request seen there.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic req);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        req = wdt_rst_req;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    logic        req;
    logic [31:0] rv;

    initial begin
        #(200000 * 8);
        n_total++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        rd(2'd0, rv); check("R1 cfg_a", int'(rv), 32'h1FFF);
        rd(2'd1, rv); check("R1 cfg_b", int'(rv), 32'h0FFF);
        rd(2'd2, rv); check("R1 count/run", int'(rv), 0);
        rd(2'd3, rv); check("R1 lock", int'(rv), 0);
        check("R1 err", int'(wdt_err), 0);
        check("R1 req", int'(wdt_rst_req), 0);

        // Vector table: window decision (R3, R4, R5, R7)
        for (int i = 0; i < NV; i++) begin
            int r, d, n, w, en, cexp, accept;
            r  = int'(VEC[i][40:29]);
            d  = int'(VEC[i][28:17]);
            n  = int'(VEC[i][16:13]);
            w  = int'(VEC[i][12:1]);
            en = int'(VEC[i][0]);
            do_reset();
            wr(2'd0, {18'd0, 1'b0, en[0], r[11:0]}, req);
            wr(2'd1, {17'd0, n[2:0], d[11:0]}, req);
            wr(2'd2, KICK, req);
            repeat (w) @(negedge clk);
            cexp = r - (w >> n);
            accept = (cexp <= d) ? 1 : 0;
            rd(2'd2, rv); check("R3 prescaled count", int'(rv[11:0]), cexp);
            wr(2'd2, KICK, req);
            check("R5 window error", int'(wdt_err), 1 - accept);
            check("R7 pulse on window error", int'(req), (1 - accept) * en);
            rd(2'd2, rv);
            check("R4 count after kick", int'(rv[11:0]), accept ? r : cexp);
            @(negedge clk);
            check("R7 pulse one cycle", int'(wdt_rst_req), 0);
        end

        // R2: wrong key and missing restart bit are ignored
        do_reset();
        wr(2'd2, 32'h5FA1_0001, req);
        rd(2'd2, rv); check("R2 bad key ignored", int'(rv), 0);
        wr(2'd2, 32'h5FA0_0000, req);
        rd(2'd2, rv); check("R2 no restart bit ignored", int'(rv), 0);
        wr(2'd2, KICK, req);
        rd(2'd2, rv); check("R2 keyed start", int'(rv), 32'h1FFF);

        // R6, R7: underflow with reset enabled
        do_reset();
        wr(2'd0, 32'h0000_1003, req);
        wr(2'd2, KICK, req);
        repeat (3) @(negedge clk);
        rd(2'd2, rv); check("R6 count at zero", int'(rv), 32'h1000);
        check("R6 no error at zero", int'(wdt_err), 0);
        @(negedge clk);
        check("R6 underflow error", int'(wdt_err), 1);
        check("R7 underflow pulse", int'(wdt_rst_req), 1);
        rd(2'd2, rv); check("R6 stopped", int'(rv), 0);
        @(negedge clk);
        check("R7 pulse ends", int'(wdt_rst_req), 0);

        // R8: error stays after an accepted reload
        wr(2'd2, KICK, req);
        repeat (3) @(negedge clk);
        wr(2'd2, KICK, req);
        check("R8 error sticky", int'(wdt_err), 1);

        // R7: underflow with reset disabled
        do_reset();
        wr(2'd0, 32'h0000_0002, req);
        wr(2'd2, KICK, req);
        repeat (3) @(negedge clk);
        check("R6 error no enable", int'(wdt_err), 1);
        check("R7 no pulse when disabled", int'(wdt_rst_req), 0);

        // R9: lock and unlock
        do_reset();
        wr(2'd3, 32'h0000_1234, req);
        rd(2'd3, rv); check("R9 locked", int'(rv), 1);
        wr(2'd0, 32'h0000_0010, req);
        rd(2'd0, rv); check("R9 cfg_a held", int'(rv), 32'h1FFF);
        wr(2'd1, 32'h0000_0010, req);
        rd(2'd1, rv); check("R9 cfg_b held", int'(rv), 32'h0FFF);
        wr(2'd2, KICK, req);
        rd(2'd2, rv); check("R9 control writable", int'(rv), 32'h1FFF);
        wr(2'd3, 32'h0000_35CA, req);
        rd(2'd3, rv); check("R9 unlocked", int'(rv), 0);
        wr(2'd0, 32'h0000_0010, req);
        rd(2'd0, rv); check("R9 cfg_a written", int'(rv), 32'h10);

        // R10: halting by power and debug state
        do_reset();
        wr(2'd0, 32'h0000_1064, req);
        wr(2'd2, KICK, req);
        repeat (5) @(negedge clk);
        pm_deep2 = 1'b1;
        repeat (10) @(negedge clk);
        rd(2'd2, rv); check("R10 deep2 holds", int'(rv[11:0]), 95);
        pm_deep2 = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd2, rv); check("R10 resume", int'(rv[11:0]), 90);
        pm_sleep = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd2, rv); check("R10 sleep runs without halt bit", int'(rv[11:0]), 86);
        pm_sleep = 1'b0;
        wr(2'd0, 32'h0000_3064, req);
        rd(2'd2, rv); check("R10 count before deep1", int'(rv[11:0]), 85);
        pm_deep1 = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd2, rv); check("R10 deep1 holds with halt bit", int'(rv[11:0]), 85);
        pm_deep1 = 1'b0;
        dbg_active = 1'b1; dbg_freeze = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd2, rv); check("R10 debug freeze holds", int'(rv[11:0]), 85);
        dbg_freeze = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd2, rv); check("R10 debug runs", int'(rv[11:0]), 82);
        dbg_active = 1'b0;

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule